// File: doc/BRIEF.md
# Transmit Descriptor Ring Fetcher

This block walks a ring of transmit descriptors held in memory and hands each one downstream. Software sets up the ring with three writes through a small register port: the start address of the ring, the number of slots in it (written as count minus one), and a tail address. The tail address is the first slot software has not yet filled. Every slot from the current pointer up to, but not including, the tail belongs to the engine.

Each descriptor occupies four consecutive 32-bit words (16 bytes). The engine reads them one word at a time over a request/acknowledge memory port. It then offers the whole descriptor as a single 128-bit beat on a valid/ready output. Once that beat is accepted, the pointer moves to the next slot. After the last slot, the pointer returns to the ring start.

When the pointer catches up with the tail, the engine stops and raises a suspended flag. Moving the tail forward wakes it up again. The current descriptor address is always visible on an output.

Top module: `desc_ring_fetch`

## Requirements
- R1: After reset the engine is suspended: `suspended` is 1, `cur_addr` is 0, and `mem_req` and `desc_valid` are 0.
- R2: A descriptor at address A is read as four word requests at A, A+4, A+8 and A+12, in that order. Each request and its address are held until `mem_ack`.
- R3: The word read from A+4k appears at `desc_data[32k+31:32k]`. `desc_valid` and `desc_data` stay stable until `desc_ready` is 1.
- R4: `cur_addr` advances by 16 only in the cycle a beat is accepted. Under backpressure no descriptor is skipped or repeated.
- R5: When the pointer equals the tail the engine is suspended: `suspended` is 1 and no memory request is issued.
- R6: A tail write to an address other than the current one resumes fetching. `suspended` returns to 0 within two cycles.
- R7: After the slot with index equal to the ring-length value is consumed, `cur_addr` returns to the ring start.
- R8: Writes to the ring start (select 0) or ring length (select 1) take effect only while suspended and are ignored otherwise. A ring-start write moves both the current pointer and the tail to the new start.
- R9: A tail write (select 2) equal to the current address while suspended keeps the engine suspended and issues no memory request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select: 0 ring start, 1 ring length minus one, 2 tail address |
| cfg_wdata | input | AW | Register write data |
| cur_addr | output | AW | Address of the current descriptor slot |
| suspended | output | 1 | Engine is stopped at the tail |
| mem_req | output | 1 | Word read request |
| mem_addr | output | AW | Word read address |
| mem_ack | input | 1 | Read acknowledge; `mem_rdata` is valid with it |
| mem_rdata | input | 32 | Read data word |
| desc_valid | output | 1 | Descriptor beat valid |
| desc_ready | input | 1 | Downstream accepts the beat |
| desc_data | output | 128 | Four descriptor words, word 0 in the low bits |

## Verification
The bench holds `desc_ready` low for many cycles while a descriptor is pending. A design that advanced on fetch instead of on acceptance would move `cur_addr` early or drop the descriptor.

It also runs the pointer past the last slot with the tail placed behind it in address terms. A plain greater-than comparison, or a wrap at the wrong index, would then stop early or run off the ring.

Ring-start and ring-length writes are issued mid-fetch. A design that accepted them would fetch from the wrong addresses or wrap at the wrong slot later.

Finally, a tail write equal to the current pointer must not start a spurious fetch.

// File: rtl/desc_ring_fetch.sv
module desc_ring_fetch #(
  parameter int AW   = 32,
  parameter int IDXW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [AW-1:0] cfg_wdata,
  output logic [AW-1:0] cur_addr,
  output logic          suspended,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata,
  output logic          desc_valid,
  input  logic          desc_ready,
  output logic [127:0]  desc_data
);
  localparam int SLOT_SH = 4;
  localparam int WORDS   = 4;

  typedef enum logic [1:0] {S_SUSP, S_RD, S_OUT} state_t;

  state_t          state_q;
  logic [AW-1:0]   base_q;
  logic [IDXW-1:0] len_q, tail_q, cur_q;
  logic [1:0]      wsel_q;
  logic [127:0]    desc_q;

  logic            wr_base, wr_len, wr_tail;
  logic [AW-1:0]   tail_off;
  logic [IDXW-1:0] tail_new, tail_eff, cur_nxt;

  assign wr_base  = cfg_we && cfg_sel == 2'd0 && state_q == S_SUSP;
  assign wr_len   = cfg_we && cfg_sel == 2'd1 && state_q == S_SUSP;
  assign wr_tail  = cfg_we && cfg_sel == 2'd2;
  assign tail_off = cfg_wdata - base_q;
  assign tail_new = tail_off[SLOT_SH +: IDXW];
  assign tail_eff = wr_tail ? tail_new : tail_q;
  assign cur_nxt  = (cur_q == len_q) ? '0 : cur_q + 1'b1;

  assign cur_addr   = base_q + (AW'(cur_q) << SLOT_SH);
  assign mem_addr   = cur_addr + (AW'(wsel_q) << 2);
  assign mem_req    = state_q == S_RD;
  assign desc_valid = state_q == S_OUT;
  assign suspended  = state_q == S_SUSP;
  assign desc_data  = desc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_SUSP;
      base_q  <= '0;
      len_q   <= '0;
      tail_q  <= '0;
      cur_q   <= '0;
      wsel_q  <= '0;
      desc_q  <= '0;
    end else begin
      if (wr_base) begin
        base_q <= cfg_wdata;
        cur_q  <= '0;
        tail_q <= '0;
      end
      if (wr_len)  len_q  <= cfg_wdata[IDXW-1:0];
      if (wr_tail) tail_q <= tail_new;
      case (state_q)
        S_SUSP: begin
          wsel_q <= '0;
          if (cur_q != tail_q && !wr_base) state_q <= S_RD;
        end
        S_RD: if (mem_ack) begin
          desc_q[32*wsel_q +: 32] <= mem_rdata;
          wsel_q <= wsel_q + 1'b1;
          if (wsel_q == 2'(WORDS - 1)) state_q <= S_OUT;
        end
        S_OUT: if (desc_ready) begin
          cur_q   <= cur_nxt;
          state_q <= (cur_nxt == tail_eff) ? S_SUSP : S_RD;
        end
        default: state_q <= S_SUSP;
      endcase
    end
  end
endmodule

module desc_ring_fetch_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_we,
  input logic [1:0]    cfg_sel,
  input logic [AW-1:0] cfg_wdata,
  input logic [AW-1:0] cur_addr,
  input logic          suspended,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ack,
  input logic [31:0]   mem_rdata,
  input logic          desc_valid,
  input logic          desc_ready,
  input logic [127:0]  desc_data
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr)); // R2
  AST_NO_REQ_WHILE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && desc_valid)); // R2
  AST_BEAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready |=> desc_valid && $stable(desc_data)); // R3
  AST_PTR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    desc_valid && !desc_ready && !cfg_we |=> $stable(cur_addr)); // R4
  AST_QUIET_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req && !desc_valid); // R5
  AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && $past(mem_req) |=> !mem_req || mem_addr == $past(mem_addr) + 4); // R2
endmodule

bind desc_ring_fetch desc_ring_fetch_chk #(.AW(AW)) chk_i (.*);

// File: tb/desc_ring_fetch_tb_top.sv
module desc_ring_fetch_tb_top;
  logic         clk = 0, rst_n = 0, cfg_we = 0, mem_ack = 0, desc_ready = 1;
  logic [1:0]   cfg_sel = 0;
  logic [31:0]  cfg_wdata = 0, cur_addr, mem_addr, mem_rdata = 0;
  logic         suspended, mem_req, desc_valid;
  logic [127:0] desc_data;
  int checks = 0, errors = 0, n = 0;
  logic [31:0]  rec_addr [32];
  logic [127:0] rec_data [32];

  always #4 clk = ~clk;

  desc_ring_fetch dut_i (.*);

  function automatic logic [31:0] f(logic [31:0] a);
    return a ^ 32'hDEAD_0000;
  endfunction

  always @(posedge clk) begin
    mem_ack   <= mem_req && !mem_ack;
    mem_rdata <= f(mem_addr);
  end

  always @(negedge clk)
    if (rst_n && desc_valid && desc_ready && n < 32) begin
      rec_addr[n] = cur_addr;
      rec_data[n] = desc_data;
      n++;
    end

  task automatic chk(string r, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", r, act, exp);
    end
  endtask

  task automatic cyc(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic cfg(logic [1:0] s, logic [31:0] d);
    @(posedge clk); #1;
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  task automatic wait_susp(string r);
    int t = 0;
    cyc(3);
    while (!suspended && t < 2000) begin
      cyc(1);
      t++;
    end
    chk(r, 128'(suspended), 128'd1);
  endtask

  task automatic chk_desc(string r, int i, logic [31:0] a);
    chk(r, 128'(rec_addr[i]), 128'(a));
    chk(r, rec_data[i], {f(a + 12), f(a + 8), f(a + 4), f(a)});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1", 128'(suspended), 128'd1);
    chk("R1", 128'(cur_addr), 128'd0);
    chk("R1", 128'({mem_req, desc_valid}), 128'd0);
  endtask

  task automatic t_basic;
    cfg(0, 32'h1000);
    cfg(1, 7);
    cfg(2, 32'h1030);
    cyc(1);
    chk("R6", 128'(suspended), 128'd0);
    wait_susp("R5");
    chk("R2", 128'(n), 128'd3);
    for (int i = 0; i < 3; i++) chk_desc("R3", i, 32'h1000 + 32'(16 * i));
    chk("R4", 128'(cur_addr), 128'h1030);
    cyc(5);
    chk("R5", 128'(mem_req), 128'd0);
  endtask

  task automatic t_backpressure;
    logic [127:0] held;
    desc_ready = 0;
    cfg(2, 32'h1040);
    cyc(20);
    @(negedge clk);
    held = desc_data;
    chk("R4", 128'(desc_valid), 128'd1);
    chk("R4", 128'(cur_addr), 128'h1030);
    chk("R4", 128'(n), 128'd3);
    cyc(6);
    chk("R3", desc_data, held);
    desc_ready = 1;
    wait_susp("R5");
    chk("R4", 128'(n), 128'd4);
    chk_desc("R4", 3, 32'h1030);
    chk("R4", 128'(cur_addr), 128'h1040);
  endtask

  task automatic t_ignore;
    desc_ready = 0;
    cfg(2, 32'h1060);
    cyc(12);
    chk("R6", 128'(suspended), 128'd0);
    cfg(0, 32'h2000);
    cfg(1, 1);
    @(negedge clk);
    chk("R8", 128'(cur_addr), 128'h1040);
    desc_ready = 1;
    wait_susp("R8");
    chk("R8", 128'(n), 128'd6);
    chk_desc("R8", 4, 32'h1040);
    chk_desc("R8", 5, 32'h1050);
    chk("R8", 128'(cur_addr), 128'h1060);
  endtask

  task automatic t_wrap;
    cfg(2, 32'h1010);
    wait_susp("R7");
    chk("R7", 128'(n), 128'd9);
    chk_desc("R7", 6, 32'h1060);
    chk_desc("R7", 7, 32'h1070);
    chk_desc("R7", 8, 32'h1000);
    chk("R7", 128'(cur_addr), 128'h1010);
  endtask

  task automatic t_equal;
    cfg(2, 32'h1010);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req || !suspended) begin
        chk("R9", 128'({mem_req, suspended}), 128'b01);
        break;
      end
    end
    chk("R9", 128'(n), 128'd9);
    chk("R9", 128'(suspended), 128'd1);
  endtask

  task automatic t_rebase;
    cfg(0, 32'h3000);
    @(negedge clk);
    chk("R8", 128'(cur_addr), 128'h3000);
    cfg(1, 1);
    cfg(2, 32'h3010);
    wait_susp("R6");
    chk_desc("R6", 9, 32'h3000);
    cfg(2, 32'h3000);
    wait_susp("R7");
    chk("R7", 128'(n), 128'd11);
    chk_desc("R7", 10, 32'h3010);
    chk("R7", 128'(cur_addr), 128'h3000);
  endtask

  initial begin
    cyc(4);
    rst_n = 1;
    t_reset;
    t_basic;
    t_backpressure;
    t_ignore;
    t_wrap;
    t_equal;
    t_rebase;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act timeout exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule